// File: doc/BRIEF.md
# USB Start-of-Frame Timing Tracker

This block tracks the frame timing of a full-speed USB device. A packet decoder upstream sends it a one-cycle pulse for each valid start-of-frame token, together with the 11-bit frame number that the token carried. The tracker keeps its own copy of the frame number. It also runs a local frame timer that restarts on every real start-of-frame. If a frame boundary passes by more than a small tolerance and no token has arrived, the tracker makes an artificial start-of-frame and advances the frame number by itself. This keeps isochronous scheduling going when tokens are lost.

Three sticky event flags are reported in a 16-bit status word: a real start-of-frame, an artificial start-of-frame, and a frame number that equals a value software has programmed. Software clears a flag by writing a 1 to it. A mask enables each flag onto a single interrupt line. The default frame length is 48,000 clocks, which is one millisecond at 48 MHz. The default tolerance is 64 clocks.

Top module: `sof_frame_tracker`

## Requirements
- R1: While reset is active and immediately after it, `status_o` is 0, `frame_num_o` is 0 and `irq_o` is 0. Every mask bit resets to 0 (disabled), and the match value resets to 0.
- R2: When `sof_valid_i` is high at a rising edge, `status_o[12]` is 1 and `frame_num_o` equals the `sof_frame_i` value sampled at that edge, from the next cycle on.
- R3: Suppose the last real start-of-frame was sampled at edge E and no further one arrives. An artificial start-of-frame is then sampled at edge E+PERIOD+TOL, and again every PERIOD edges after that. Each one sets `status_o[13]` and increments `frame_num_o` by 1, visible after that edge.
- R4: A real start-of-frame sampled at any edge up to and including the deadline edge resynchronises the timer, and no artificial start-of-frame is made for that frame.
- R5: `status_o[14]` is set when a start-of-frame event of either kind yields a frame number equal to the match value. The match value used is the one held before that edge; `match_we_i` loads `match_data_i` into it.
- R6: The status flags are sticky. When `clr_we_i` is high, a flag clears only if its bit in `clr_i` is 1; a 0 in `clr_i` has no effect. The bits of `clr_i` and `mask_i` map to status bits as index 0 to bit 12, index 1 to bit 13, and index 2 to bit 14. All other status bits read as 0.
- R7: When an event and a clear of the same flag happen in the same cycle, the flag stays set.
- R8: `irq_o` is the OR of the status flags ANDed with their mask bits. `mask_we_i` loads `mask_i`, and the new mask takes effect from the next cycle.
- R9: An artificial start-of-frame at frame number 2^FN_W-1 wraps the frame number to 0.
- R10: After reset, no artificial start-of-frame is made until at least one real start-of-frame has been sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; 48 MHz at the default frame length |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_valid_i | input | 1 | One-cycle pulse: a valid start-of-frame token was decoded |
| sof_frame_i | input | FN_W | Frame number carried by the token |
| match_we_i | input | 1 | Load the match value |
| match_data_i | input | FN_W | New match value |
| mask_we_i | input | 1 | Load the interrupt mask |
| mask_i | input | 3 | Mask bits {match, artificial, real} |
| clr_we_i | input | 1 | Write-one-to-clear strobe for the status flags |
| clr_i | input | 3 | Clear bits {match, artificial, real} |
| frame_num_o | output | FN_W | Current local frame number |
| status_o | output | 16 | Status word: bit 14 match, bit 13 artificial, bit 12 real |
| irq_o | output | 1 | Masked interrupt request |

## Verification
Some rules are checked by the bound checker on every cycle:
- a real token always sets its flag and loads its number on the next cycle;
- a set flag survives every cycle in which its clear bit is not written;
- the unused status bits stay 0;
- the interrupt is never raised with no flag pending;
- no artificial flag appears before the first real token;
- no artificial flag appears earlier than PERIOD+TOL cycles after the last real one.

Other behaviour only the bench scenarios can show:
- the exact deadline cycle, and the period between repeated artificial events;
- that a token on the deadline cycle itself beats the artificial event;
- the frame-number wrap;
- the match against either event kind;
- the precedence of set over clear;
- the per-flag effect of the mask.

// File: rtl/sft_pkg.sv
package sft_pkg;
    localparam int STAT_W    = 16;
    localparam int BIT_SOF   = 12;
    localparam int BIT_ASOF  = 13;
    localparam int BIT_MATCH = 14;
    localparam int NUM_EVT   = 3;

    typedef struct packed {
        logic match;
        logic asof;
        logic sof;
    } evt_t;
endpackage

// File: rtl/sft_frame_timer.sv
module sft_frame_timer #(
    parameter int PERIOD = 48000,
    parameter int TOL    = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic real_sof_i,
    output logic art_sof_o
);
    localparam int LIMIT = PERIOD + TOL;
    localparam int CW    = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST   = CW'(LIMIT - 1);
    localparam logic [CW-1:0] RELOAD = CW'(TOL);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        art_sof_o = 1'b0;
        if (real_sof_i) begin
            s_d.armed = 1'b1;
            s_d.cnt   = '0;
        end else if (s_q.armed) begin
            if (s_q.cnt == LAST) begin
                art_sof_o = 1'b1;
                s_d.cnt   = RELOAD;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sft_frame_number.sv
module sft_frame_number #(
    parameter int FN_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            real_sof_i,
    input  logic [FN_W-1:0] frame_i,
    input  logic            art_sof_i,
    input  logic            match_we_i,
    input  logic [FN_W-1:0] match_data_i,
    output logic [FN_W-1:0] frame_o,
    output logic            match_hit_o
);
    typedef struct packed {
        logic [FN_W-1:0] fn;
        logic [FN_W-1:0] match;
    } fn_t;

    fn_t             s_d, s_q;
    logic [FN_W-1:0] fn_new;

    always_comb begin
        s_d    = s_q;
        fn_new = s_q.fn;
        if (real_sof_i)     fn_new = frame_i;
        else if (art_sof_i) fn_new = s_q.fn + 1'b1;
        match_hit_o = (real_sof_i || art_sof_i) && (fn_new == s_q.match);
        s_d.fn      = fn_new;
        if (match_we_i) s_d.match = match_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign frame_o = s_q.fn;
endmodule

// File: rtl/sft_irq_status.sv
module sft_irq_status
    import sft_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  evt_t               evt_i,
    input  logic               clr_we_i,
    input  logic [NUM_EVT-1:0] clr_i,
    input  logic               mask_we_i,
    input  logic [NUM_EVT-1:0] mask_i,
    output logic [NUM_EVT-1:0] flags_o,
    output logic               irq_o
);
    typedef struct packed {
        logic [NUM_EVT-1:0] flags;
        logic [NUM_EVT-1:0] mask;
    } irq_t;

    irq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_we_i) s_d.flags = s_q.flags & ~clr_i;
        s_d.flags = s_d.flags | evt_i;
        if (mask_we_i) s_d.mask = mask_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flags_o = s_q.flags;
    assign irq_o   = |(s_q.flags & s_q.mask);
endmodule

// File: rtl/sof_frame_tracker.sv
module sof_frame_tracker
    import sft_pkg::*;
#(
    parameter int FN_W   = 11,
    parameter int PERIOD = 48000,
    parameter int TOL    = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sof_valid_i,
    input  logic [FN_W-1:0]    sof_frame_i,
    input  logic               match_we_i,
    input  logic [FN_W-1:0]    match_data_i,
    input  logic               mask_we_i,
    input  logic [NUM_EVT-1:0] mask_i,
    input  logic               clr_we_i,
    input  logic [NUM_EVT-1:0] clr_i,
    output logic [FN_W-1:0]    frame_num_o,
    output logic [STAT_W-1:0]  status_o,
    output logic               irq_o
);
    logic               art_sof;
    logic               match_hit;
    evt_t               evt;
    logic [NUM_EVT-1:0] flags;

    sft_frame_timer #(.PERIOD(PERIOD), .TOL(TOL)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .real_sof_i (sof_valid_i),
        .art_sof_o  (art_sof)
    );

    sft_frame_number #(.FN_W(FN_W)) u_fnum (
        .clk          (clk),
        .rst_n        (rst_n),
        .real_sof_i   (sof_valid_i),
        .frame_i      (sof_frame_i),
        .art_sof_i    (art_sof),
        .match_we_i   (match_we_i),
        .match_data_i (match_data_i),
        .frame_o      (frame_num_o),
        .match_hit_o  (match_hit)
    );

    always_comb begin
        evt.match = match_hit;
        evt.asof  = art_sof;
        evt.sof   = sof_valid_i;
    end

    sft_irq_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .clr_we_i  (clr_we_i),
        .clr_i     (clr_i),
        .mask_we_i (mask_we_i),
        .mask_i    (mask_i),
        .flags_o   (flags),
        .irq_o     (irq_o)
    );

    always_comb begin
        status_o            = '0;
        status_o[BIT_SOF]   = flags[0];
        status_o[BIT_ASOF]  = flags[1];
        status_o[BIT_MATCH] = flags[2];
    end
endmodule

// File: rtl/sft_checker.sv
module sft_checker #(
    parameter int FN_W   = 11,
    parameter int PERIOD = 48000,
    parameter int TOL    = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sof_valid_i,
    input logic [FN_W-1:0] sof_frame_i,
    input logic            clr_we_i,
    input logic [2:0]      clr_i,
    input logic [FN_W-1:0] frame_num_o,
    input logic [15:0]     status_o,
    input logic            irq_o
);
    localparam int LIMIT = PERIOD + TOL;
    localparam int CW    = $clog2(LIMIT + 2);

    logic          seen_q;
    logic [CW-1:0] since_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            since_q <= '0;
        end else if (sof_valid_i) begin
            seen_q  <= 1'b1;
            since_q <= '0;
        end else if (since_q != CW'(LIMIT + 1)) begin
            since_q <= since_q + 1'b1;
        end
    end

    a_r2_sof_flag: assert property (@(posedge clk) disable iff (!rst_n)
        sof_valid_i |=> status_o[12]);

    a_r2_frame_load: assert property (@(posedge clk) disable iff (!rst_n)
        sof_valid_i |=> frame_num_o == $past(sof_frame_i));

    a_r6_sticky_sof: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[12] && !(clr_we_i && clr_i[0])) |=> status_o[12]);

    a_r6_sticky_asof: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[13] && !(clr_we_i && clr_i[1])) |=> status_o[13]);

    a_r6_sticky_match: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[14] && !(clr_we_i && clr_i[2])) |=> status_o[14]);

    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[15] == 1'b0) && (status_o[11:0] == 12'h000));

    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_o[14:12] != 3'b000));

    a_r10_no_early_asof: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !status_o[13]);

    a_r3_not_before_deadline: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[13]) |-> (since_q >= CW'(LIMIT)));
endmodule

bind sof_frame_tracker sft_checker #(.FN_W(FN_W), .PERIOD(PERIOD), .TOL(TOL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sof_valid_i (sof_valid_i),
    .sof_frame_i (sof_frame_i),
    .clr_we_i    (clr_we_i),
    .clr_i       (clr_i),
    .frame_num_o (frame_num_o),
    .status_o    (status_o),
    .irq_o       (irq_o)
);

// File: tb/sof_frame_tracker_bench.sv
module sof_frame_tracker_bench;
    localparam int CLK_P  = 10;
    localparam int FN_W   = 11;
    localparam int PERIOD = 40;
    localparam int TOL    = 4;
    localparam int LIMIT  = PERIOD + TOL;
    localparam int NVEC   = 6;
    // each vector: {expected match flag, frame number}; match value is 300
    localparam logic [11:0] VEC [NVEC] = '{
        {1'b0, 11'd5}, {1'b1, 11'd300}, {1'b0, 11'd301},
        {1'b0, 11'd0}, {1'b0, 11'd2047}, {1'b1, 11'd300}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sof_valid_i = 1'b0;
    logic [FN_W-1:0] sof_frame_i = '0;
    logic            match_we_i = 1'b0;
    logic [FN_W-1:0] match_data_i = '0;
    logic            mask_we_i = 1'b0;
    logic [2:0]      mask_i = '0;
    logic            clr_we_i = 1'b0;
    logic [2:0]      clr_i = '0;
    logic [FN_W-1:0] frame_num_o;
    logic [15:0]     status_o;
    logic            irq_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    sof_frame_tracker #(.FN_W(FN_W), .PERIOD(PERIOD), .TOL(TOL)) u_sof_frame_tracker (
        .clk(clk), .rst_n(rst_n), .sof_valid_i(sof_valid_i), .sof_frame_i(sof_frame_i),
        .match_we_i(match_we_i), .match_data_i(match_data_i), .mask_we_i(mask_we_i),
        .mask_i(mask_i), .clr_we_i(clr_we_i), .clr_i(clr_i), .frame_num_o(frame_num_o),
        .status_o(status_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic sof(input logic [FN_W-1:0] fn);
        sof_valid_i = 1'b1; sof_frame_i = fn;
        @(negedge clk);
        sof_valid_i = 1'b0;
    endtask

    task automatic clr(input logic [2:0] b);
        clr_we_i = 1'b1; clr_i = b;
        @(negedge clk);
        clr_we_i = 1'b0; clr_i = '0;
    endtask

    task automatic set_match(input logic [FN_W-1:0] v);
        match_we_i = 1'b1; match_data_i = v;
        @(negedge clk);
        match_we_i = 1'b0;
    endtask

    task automatic set_mask(input logic [2:0] m);
        mask_we_i = 1'b1; mask_i = m;
        @(negedge clk);
        mask_we_i = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        chk("R1 status in reset", 32'(status_o), 0);
        chk("R1 frame in reset", 32'(frame_num_o), 0);
        chk("R1 irq in reset", 32'(irq_o), 0);
        rst_n = 1'b1;
        idle(1);
        chk("R1 status after reset", 32'(status_o), 0);

        // R10: long idle without any real token
        idle(3 * LIMIT);
        chk("R10 no artificial before first token", 32'(status_o), 0);
        chk("R10 frame unchanged", 32'(frame_num_o), 0);

        // table walk: R2, R5 and R4 under varied frame numbers
        set_match(11'd300);
        for (int v = 0; v < NVEC; v++) begin
            clr(3'b111);
            sof(VEC[v][10:0]);
            chk("R2 frame loaded", 32'(frame_num_o), 32'(VEC[v][10:0]));
            chk("R2 sof flag", 32'(status_o[12]), 1);
            chk("R5 match flag", 32'(status_o[14]), 32'(VEC[v][11]));
            chk("R4 no artificial", 32'(status_o[13]), 0);
        end

        // R3: deadline and repeat period
        clr(3'b111);
        sof(11'd100);
        idle(LIMIT - 1);
        chk("R3 not yet artificial", 32'(status_o[13]), 0);
        chk("R3 frame held", 32'(frame_num_o), 100);
        idle(1);
        chk("R3 artificial at deadline", 32'(status_o[13]), 1);
        chk("R3 frame incremented", 32'(frame_num_o), 101);
        idle(PERIOD - 1);
        chk("R3 frame held in period", 32'(frame_num_o), 101);
        idle(1);
        chk("R3 repeat after period", 32'(frame_num_o), 102);

        // R4: token on the deadline cycle itself wins
        clr(3'b111);
        sof(11'd200);
        idle(LIMIT - 1);
        sof(11'd210);
        chk("R4 deadline token suppresses artificial", 32'(status_o[13]), 0);
        chk("R4 frame from token", 32'(frame_num_o), 210);
        idle(LIMIT - 1);
        chk("R4 resynced timer", 32'(status_o[13]), 0);
        idle(1);
        chk("R4 artificial after resync", 32'(frame_num_o), 211);

        // R9 and R5 with an artificial event
        clr(3'b111);
        set_match(11'd0);
        sof(11'd2047);
        chk("R5 no match on 2047", 32'(status_o[14]), 0);
        idle(LIMIT);
        chk("R9 wrap to zero", 32'(frame_num_o), 0);
        chk("R5 match on artificial", 32'(status_o[14]), 1);
        chk("R3 artificial flag", 32'(status_o[13]), 1);

        // R6: write-one-to-clear
        clr(3'b000);
        chk("R6 zero write keeps flags", 32'(status_o[14:12]), 32'h7);
        clr(3'b100);
        chk("R6 single clear", 32'(status_o[14:12]), 32'h3);
        chk("R6 reserved bits zero", 32'(status_o & 16'h8FFF), 0);

        // R8: mask gating
        chk("R8 masked off", 32'(irq_o), 0);
        set_mask(3'b100);
        chk("R8 mask of clear flag", 32'(irq_o), 0);
        set_mask(3'b001);
        chk("R8 enabled flag", 32'(irq_o), 1);
        clr(3'b011);
        chk("R8 cleared drops irq", 32'(irq_o), 0);

        // R7: set beats clear in the same cycle
        sof_valid_i = 1'b1; sof_frame_i = 11'd7;
        clr_we_i = 1'b1; clr_i = 3'b001;
        @(negedge clk);
        sof_valid_i = 1'b0; clr_we_i = 1'b0; clr_i = '0;
        chk("R7 set wins over clear", 32'(status_o[12]), 1);
        chk("R8 irq from new flag", 32'(irq_o), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule